// File: doc/BRIEF.md
# Ethernet MAC enable and local-reset controller

This block is the control point that switches an Ethernet MAC on and off. Software writes two control bits through a single write strobe. One bit sets or clears the MAC enable. The other starts a local reset. From these bits the block drives level strobes to the rest of the MAC:
- a receive-run and a transmit-run level;
- a request to finish the current transmit frame with a corrupted CRC;
- an inhibit that stops status write-back to the transmit descriptors;
- a hold-reset for the DMA, the descriptor logic and the FIFO pointers;
- a local-reset level for the MAC's other registers.

Shutdown is asymmetric. When the enable is cleared, reception stops in the very next cycle. A frame that is still being sent keeps the transmitter running until the transmit path reports that a bad CRC has been appended. A write that sets the reset bit starts a fixed-length local reset. During that reset every transfer is cut off at once, with no bad-CRC tail. The reset bit clears itself when the sequence ends. A bus-error flag clears the enable in hardware.

The controller has four states:
- `ST_OFF`: disabled and idle.
- `ST_ON`: enabled.
- `ST_DRAIN`: disabled, while the in-flight frame is closed out with a bad CRC.
- `ST_LRST`: the timed local reset.

Its transitions are:
- `ST_OFF`→`ST_ON` on an enabling write with no bus error in the same cycle.
- `ST_ON`→`ST_DRAIN` on a disabling write or a bus error while a transmit is in progress.
- `ST_ON`→`ST_OFF` on the same events with no transmit in progress.
- `ST_DRAIN`→`ST_OFF` when the CRC-appended handshake is seen.
- Any state other than `ST_LRST` →`ST_LRST` on a write with the reset bit set.
- `ST_LRST`→`ST_OFF` when the cycle counter reaches its last count.

Top module: `ethctl_enable_ctrl`

## Requirements
- R1: After `rst_n` is released, `mac_enable`, `rx_run`, `tx_run`, `tx_bad_crc`, `bd_wb_inhibit`, `lrst_active` and `lrst_busy` are 0, and `dma_hold_rst` is 1.
- R2: A write (`cfg_wr`=1) with `cfg_enable`=1 and `cfg_lrst`=0 while disabled and idle makes `mac_enable`, `rx_run` and `tx_run` 1 and `dma_hold_rst` 0 from the next cycle on.
- R3: A write with `cfg_enable`=0 and `cfg_lrst`=0 while enabled and `tx_busy`=0 drops `mac_enable`, `rx_run` and `tx_run` to 0 in the next cycle.
- R4: The same disabling write with `tx_busy`=1 drops `rx_run` and `mac_enable` in the next cycle. `tx_run`, `tx_bad_crc` and `bd_wb_inhibit` then stay 1 until the cycle after `crc_done` is sampled high, and all three are 0 from then on.
- R5: `dma_hold_rst` is 1 in every cycle in which `mac_enable` is 0.
- R6: A write with `cfg_lrst`=1 outside a local reset starts the local reset regardless of `cfg_enable`. `lrst_active` and `lrst_busy` are then 1 for exactly `RST_CYCLES` (default 8) cycles starting the next cycle. In those cycles `mac_enable`, `rx_run`, `tx_run` and `tx_bad_crc` are 0. After the sequence the block is disabled and idle.
- R7: Writes made while `lrst_busy` is 1 are ignored. In particular, an enabling write during the reset leaves `mac_enable` at 0 after the sequence ends.
- R8: A `bus_err` pulse while enabled clears `mac_enable` in the next cycle, with the same receive and transmit shutdown as R3/R4.
- R9: A `bus_err` in the same cycle as an enabling write wins, and `mac_enable` stays 0.
- R10: Enabling writes made during the bad-CRC drain are ignored, so `mac_enable` is still 0 after the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_enable | input | 1 | Written value of the enable bit |
| cfg_lrst | input | 1 | Written value of the local-reset bit |
| bus_err | input | 1 | Bus-error interrupt status set |
| tx_busy | input | 1 | A transmit frame is in progress |
| crc_done | input | 1 | Transmit path has appended the bad CRC |
| mac_enable | output | 1 | Enable bit readback |
| lrst_busy | output | 1 | Local-reset bit readback |
| rx_run | output | 1 | Receive path may run |
| tx_run | output | 1 | Transmit path may run |
| tx_bad_crc | output | 1 | End the current frame with a corrupted CRC |
| bd_wb_inhibit | output | 1 | Block status update of aborted transmit descriptors |
| dma_hold_rst | output | 1 | Hold DMA, descriptor and FIFO pointers reset |
| lrst_active | output | 1 | Local reset applied to the MAC's other registers |

## Verification
The assertions take for granted that `crc_done` reports only a transmit that the block let start. For that reason the drain property looks only at cycles without `crc_done`. No property assumes any spacing of `bus_err` or of writes. The random stimulus draws every input independently each cycle, including writes during a reset and a drain. Bus errors and CRC handshakes are kept rare, so that the run and drain states persist long enough to be exercised.

// File: rtl/ethctl_pkg.sv
package ethctl_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_DRAIN = 2'd2,
        ST_LRST  = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/ethctl_rst_timer.sv
module ethctl_rst_timer #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic last
);
    localparam int CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign last = active && (cnt == LAST_CNT);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> (cnt != '0)) else $error("counter stalled"); // R6
endmodule

// File: rtl/ethctl_fsm.sv
module ethctl_fsm
    import ethctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_enable,
    input  logic       cfg_lrst,
    input  logic       bus_err,
    input  logic       tx_busy,
    input  logic       crc_done,
    input  logic       lrst_last,
    output ctl_state_t state
);
    ctl_state_t nxt;
    logic       wr_reset, wr_on, wr_off;

    assign wr_reset = cfg_wr && cfg_lrst;
    assign wr_on    = cfg_wr && !cfg_lrst && cfg_enable;
    assign wr_off   = cfg_wr && !cfg_lrst && !cfg_enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LRST: begin
                if (lrst_last)
                    nxt = ST_OFF;
            end
            ST_OFF: begin
                if (wr_reset)
                    nxt = ST_LRST;
                else if (wr_on && !bus_err)
                    nxt = ST_ON;
            end
            ST_ON: begin
                if (wr_reset)
                    nxt = ST_LRST;
                else if (bus_err || wr_off)
                    nxt = tx_busy ? ST_DRAIN : ST_OFF;
            end
            ST_DRAIN: begin
                if (wr_reset)
                    nxt = ST_LRST;
                else if (crc_done)
                    nxt = ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
    end

    AST_BERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> (state != ST_ON)) else $error("enable survived bus error"); // R9
    AST_LRST_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LRST && !lrst_last) |=> (state == ST_LRST)) else $error("reset cut short"); // R7
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !crc_done && !wr_reset) |=> (state == ST_DRAIN)) else $error("drain left early"); // R4
    AST_LRST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LRST && wr_reset) |=> (state == ST_LRST)) else $error("reset write lost"); // R6
endmodule

// File: rtl/ethctl_strobe_dec.sv
module ethctl_strobe_dec
    import ethctl_pkg::*;
(
    input  ctl_state_t state,
    output logic       mac_enable,
    output logic       lrst_busy,
    output logic       rx_run,
    output logic       tx_run,
    output logic       tx_bad_crc,
    output logic       bd_wb_inhibit,
    output logic       dma_hold_rst,
    output logic       lrst_active
);
    always_comb begin
        mac_enable    = 1'b0;
        lrst_busy     = 1'b0;
        rx_run        = 1'b0;
        tx_run        = 1'b0;
        tx_bad_crc    = 1'b0;
        bd_wb_inhibit = 1'b0;
        dma_hold_rst  = 1'b1;
        lrst_active   = 1'b0;
        unique case (state)
            ST_OFF: ;
            ST_ON: begin
                mac_enable   = 1'b1;
                rx_run       = 1'b1;
                tx_run       = 1'b1;
                dma_hold_rst = 1'b0;
            end
            ST_DRAIN: begin
                tx_run        = 1'b1;
                tx_bad_crc    = 1'b1;
                bd_wb_inhibit = 1'b1;
            end
            ST_LRST: begin
                lrst_busy   = 1'b1;
                lrst_active = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ethctl_enable_ctrl.sv
module ethctl_enable_ctrl
    import ethctl_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_enable,
    input  logic cfg_lrst,
    input  logic bus_err,
    input  logic tx_busy,
    input  logic crc_done,
    output logic mac_enable,
    output logic lrst_busy,
    output logic rx_run,
    output logic tx_run,
    output logic tx_bad_crc,
    output logic bd_wb_inhibit,
    output logic dma_hold_rst,
    output logic lrst_active
);
    ctl_state_t state;
    logic       lrst_last;

    ethctl_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == ST_LRST),
        .last   (lrst_last)
    );

    ethctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_enable (cfg_enable),
        .cfg_lrst   (cfg_lrst),
        .bus_err    (bus_err),
        .tx_busy    (tx_busy),
        .crc_done   (crc_done),
        .lrst_last  (lrst_last),
        .state      (state)
    );

    ethctl_strobe_dec u_dec (
        .state         (state),
        .mac_enable    (mac_enable),
        .lrst_busy     (lrst_busy),
        .rx_run        (rx_run),
        .tx_run        (tx_run),
        .tx_bad_crc    (tx_bad_crc),
        .bd_wb_inhibit (bd_wb_inhibit),
        .dma_hold_rst  (dma_hold_rst),
        .lrst_active   (lrst_active)
    );

    AST_RX_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_enable && cfg_wr && !cfg_enable) |=> !rx_run) else $error("rx kept running"); // R3
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_enable |-> dma_hold_rst) else $error("dma hold missing"); // R5
    AST_LRST_ABRUPT: assert property (@(posedge clk) disable iff (!rst_n)
        lrst_active |-> !(tx_run || tx_bad_crc || rx_run)) else $error("transfer during reset"); // R6
    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mac_enable, tx_bad_crc, lrst_active})) else $error("modes overlap"); // R4
endmodule

// File: tb/sim_ethctl_enable_ctrl.sv
module sim_ethctl_enable_ctrl;
    localparam int NRST = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_enable = 0, cfg_lrst = 0, bus_err = 0, tx_busy = 0, crc_done = 0;
    logic mac_enable, lrst_busy, rx_run, tx_run, tx_bad_crc, bd_wb_inhibit, dma_hold_rst, lrst_active;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // model: 0 off, 1 on, 2 drain, 3 local reset
    int m_st = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    ethctl_enable_ctrl #(.RST_CYCLES(NRST)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
        .cfg_lrst(cfg_lrst), .bus_err(bus_err), .tx_busy(tx_busy), .crc_done(crc_done),
        .mac_enable(mac_enable), .lrst_busy(lrst_busy), .rx_run(rx_run), .tx_run(tx_run),
        .tx_bad_crc(tx_bad_crc), .bd_wb_inhibit(bd_wb_inhibit), .dma_hold_rst(dma_hold_rst),
        .lrst_active(lrst_active)
    );

    function automatic int nxt_st(int st, int cnt, bit wr, bit en, bit rs, bit be, bit tb, bit cd);
        if (st == 3) return (cnt == NRST - 1) ? 0 : 3;
        if (wr && rs) return 3;
        if (st == 0) return (wr && en && !be) ? 1 : 0;
        if (st == 1) return (be || (wr && !en)) ? (tb ? 2 : 0) : 1;
        return cd ? 0 : 2;
    endfunction

    function automatic logic [7:0] exp_out(int st);
        // {enable, busy, rx, tx, badcrc, inhibit, hold, lrst}
        case (st)
            1: return 8'b1011_0000;
            2: return 8'b0001_1110;
            3: return 8'b0100_0011;
            default: return 8'b0000_0010;
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all();
        logic [7:0] e;
        e = exp_out(m_st);
        chk("R2 mac_enable",    mac_enable,    e[7]);
        chk("R6 lrst_busy",     lrst_busy,     e[6]);
        chk("R3 rx_run",        rx_run,        e[5]);
        chk("R4 tx_run",        tx_run,        e[4]);
        chk("R4 tx_bad_crc",    tx_bad_crc,    e[3]);
        chk("R4 bd_wb_inhibit", bd_wb_inhibit, e[2]);
        chk("R5 dma_hold_rst",  dma_hold_rst,  e[1]);
        chk("R6 lrst_active",   lrst_active,   e[0]);
    endtask

    // drive at negedge, advance model, check at the following negedge
    task automatic step(bit wr, bit en, bit rs, bit be, bit tb, bit cd);
        int ns;
        cfg_wr = wr; cfg_enable = en; cfg_lrst = rs;
        bus_err = be; tx_busy = tb; crc_done = cd;
        ns = nxt_st(m_st, m_cnt, wr, en, rs, be, tb, cd);
        m_cnt = (m_st == 3 && ns == 3) ? m_cnt + 1 : 0;
        m_st = ns;
        @(negedge clk);
        chk_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(); // R1 reset state

        step(1, 1, 0, 0, 0, 0);               // R2 enable
        chk("R2 enable set", mac_enable, 1'b1);
        step(1, 0, 0, 0, 0, 0);               // R3 disable, no tx
        chk("R3 tx stopped", tx_run, 1'b0);

        step(1, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0);               // R4 disable during tx
        chk("R4 rx halted", rx_run, 1'b0);
        chk("R4 bad crc", tx_bad_crc, 1'b1);
        step(1, 1, 0, 0, 1, 0);               // R10 enable ignored while draining
        step(0, 0, 0, 0, 1, 1);               // crc appended
        chk("R4 drain done", tx_run, 1'b0);
        chk("R10 still off", mac_enable, 1'b0);

        step(1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0);               // R8 bus error while busy
        chk("R8 enable cleared", mac_enable, 1'b0);
        step(0, 0, 0, 0, 0, 1);

        step(1, 1, 0, 1, 0, 0);               // R9 bus error beats set
        chk("R9 stays off", mac_enable, 1'b0);

        step(1, 1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 1, 0);               // R6 local reset from on
        for (int i = 1; i < NRST; i++) begin
            step(1, 1, 0, 0, 0, 0);           // R7 ignored writes
            chk("R7 busy held", lrst_busy, 1'b1);
        end
        step(0, 0, 0, 0, 0, 0);
        chk("R6 reset ended", lrst_busy, 1'b0);
        chk("R7 enable off after reset", mac_enable, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            bit wr, en, rs, be, tb, cd;
            wr = ($urandom_range(0, 3) == 0);
            en = $urandom_range(0, 1);
            rs = ($urandom_range(0, 15) == 0);
            be = ($urandom_range(0, 19) == 0);
            tb = $urandom_range(0, 1);
            cd = ($urandom_range(0, 5) == 0);
            step(wr, en, rs, be, tb, cd);
        end
        idle(NRST + 2);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule